// File: doc/BRIEF.md
# Snooping Bus Controller with Cache-to-Cache Intervention

This block sits between a set of write-back caches that keep their lines in the four MESI states and a single main memory. It owns the shared bus: it picks one requesting cache at a time and holds its grant for the whole transaction. It broadcasts that cache's command and address to every snooper. Two cycles later it samples the snoop replies and decides where the data comes from.

If any other cache reports a hit on a read or read-for-ownership, the lowest-numbered such cache is selected to drive the line. The outstanding memory read is cancelled. When the selected cache held the line Modified, the same data is written into memory in the same cycle. With no hit the controller waits for memory. An invalidate has no data phase. In every case the requester receives a shared flag that is the OR of the other caches' hits.

Top module: `snp_bus_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `gnt`, `bus_valid`, `bus_done`, `bus_data_valid`, `mem_rd_req`, `mem_rd_abort` and `mem_wr` are all 0.
- R2: Requests are granted round-robin: the search starts at the cache after the previous winner (cache 0 first after reset). `gnt` is one-hot from the address cycle through the `bus_done` cycle inclusive. It is 0 in the cycle after `bus_done`.
- R3: The address phase is the first granted cycle. It is one cycle of `bus_valid` carrying the winner's command, address and index on `bus_cmd`, `bus_addr` and `bus_src`. Command codes are 01 read, 10 read-for-ownership and 11 invalidate. `mem_rd_req` pulses in that cycle for codes 01 and 10 only.
- R4: `snp_hit`/`snp_dirty` are used only in the cycle two cycles after the address phase. The requester's own reply is always ignored.
- R5: `bus_shared` is 1 during `bus_done` exactly when some non-requesting cache reported a hit in the sampled cycle.
- R6: On a read or read-for-ownership with at least one non-requesting hit, the cycle after sampling shows the following together: `bus_data_valid`, `bus_done` and `mem_rd_abort`; `bus_data` equal to the data lane of the lowest-numbered hitting cache; and `bus_supplier` one-hot on that cache.
- R7: If that supplier also reported `snp_dirty`, `mem_wr` is 1 in the same cycle, with `mem_wr_addr` equal to the transaction address and `mem_wr_data` equal to the supplied data. Otherwise `mem_wr` stays 0.
- R8: On a read with no non-requesting hit, the controller waits for memory. In the first cycle `mem_rd_valid` is 1, it presents `mem_rd_data` with `bus_data_valid` and `bus_done`.
- R9: `mem_rd_valid` has no effect outside that wait: a memory reply after an intervention raises neither `bus_data_valid` nor `bus_done`.
- R10: An invalidate (code 11) completes with `bus_done` in the cycle after sampling. It has no `bus_data_valid`, no memory read and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Per-cache bus request, held until its `bus_done` |
| req_cmd | input | 2*N | Per-cache command code (01 read, 10 read-for-ownership, 11 invalidate) |
| req_addr | input | N*AW | Per-cache line address |
| gnt | output | N | One-hot grant |
| bus_valid | output | 1 | Address phase strobe |
| bus_cmd | output | 2 | Broadcast command, held during the grant |
| bus_addr | output | AW | Broadcast address, held during the grant |
| bus_src | output | IDW | Index of the granted cache |
| snp_hit | input | N | Per-cache snoop hit reply |
| snp_dirty | input | N | Per-cache reply: line held Modified |
| snp_data | input | N*DW | Per-cache data lanes for intervention |
| bus_supplier | output | N | One-hot: cache selected to supply data |
| bus_data | output | DW | Data delivered to the requester |
| bus_data_valid | output | 1 | `bus_data` is valid |
| bus_shared | output | 1 | Another cache holds the line (valid with `bus_done`) |
| bus_done | output | 1 | Transaction completes this cycle |
| mem_rd_req | output | 1 | Memory read request (address on `bus_addr`) |
| mem_rd_abort | output | 1 | Cancel the outstanding memory read |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | DW | Memory read data |
| mem_wr | output | 1 | Memory write of a Modified line |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |

## Verification
The assertions rely on several properties of the inputs. A requesting cache keeps `req`, command and address stable until its `bus_done`. A supplying cache keeps its data lane steady in the cycle after sampling. Memory answers no earlier than the cycle after sampling, and only once per request. In the stimulus, memory replies exactly four cycles after the request, and every cache lane carries fixed, distinct data. Hit and dirty lines carry all-ones noise outside the sampling cycle, so a controller that samples them at the wrong time is caught; meanwhile they never break any of the input assumptions above.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_READ = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_INV  = 2'b11
  } snp_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_SAMPLE,
    ST_CACHE,
    ST_INVDONE,
    ST_MEM
  } bus_st_e;

endpackage

// File: rtl/snp_rr_arb.sv
module snp_rr_arb #(
  parameter int N = 4,
  localparam int IDW = $clog2(N)
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] last,
  output logic           any,
  output logic [IDW-1:0] win
);

  int idx;

  // Walk from farthest to nearest so the cache right after `last` wins.
  always_comb begin
    any = 1'b0;
    win = last;
    idx = 0;
    for (int k = N; k >= 1; k--) begin
      idx = (int'(last) + k) % N;
      if (req[idx]) begin
        any = 1'b1;
        win = IDW'(idx);
      end
    end
  end

endmodule

// File: rtl/snp_resp_sel.sv
module snp_resp_sel #(
  parameter int N = 4,
  localparam int IDW = $clog2(N)
) (
  input  logic [N-1:0]   hit,
  input  logic [N-1:0]   dirty,
  input  logic [IDW-1:0] self_id,
  output logic           any_hit,
  output logic [IDW-1:0] sup_id,
  output logic           sup_dirty
);

  logic [N-1:0] others;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign others[g] = hit[g] && (self_id != IDW'(g));
  end

  assign any_hit = |others;

  // Lowest-numbered responder is assigned last and therefore wins.
  always_comb begin
    sup_id    = '0;
    sup_dirty = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (others[i]) begin
        sup_id    = IDW'(i);
        sup_dirty = dirty[i];
      end
    end
  end

endmodule

// File: rtl/snp_bus_ctrl.sv
module snp_bus_ctrl
  import snp_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int IDW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [2*N-1:0]  req_cmd,
  input  logic [N*AW-1:0] req_addr,
  output logic [N-1:0]    gnt,
  output logic            bus_valid,
  output logic [1:0]      bus_cmd,
  output logic [AW-1:0]   bus_addr,
  output logic [IDW-1:0]  bus_src,
  input  logic [N-1:0]    snp_hit,
  input  logic [N-1:0]    snp_dirty,
  input  logic [N*DW-1:0] snp_data,
  output logic [N-1:0]    bus_supplier,
  output logic [DW-1:0]   bus_data,
  output logic            bus_data_valid,
  output logic            bus_shared,
  output logic            bus_done,
  output logic            mem_rd_req,
  output logic            mem_rd_abort,
  input  logic            mem_rd_valid,
  input  logic [DW-1:0]   mem_rd_data,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DW-1:0]   mem_wr_data
);

  bus_st_e        st_q, st_d;
  logic [IDW-1:0] owner_q, last_q;
  snp_cmd_e       cmd_q;
  logic [AW-1:0]  addr_q;
  logic           shared_q, supdirty_q;
  logic [IDW-1:0] sup_q;

  logic           arb_any;
  logic [IDW-1:0] arb_win;
  logic           rsp_any;
  logic [IDW-1:0] rsp_sup;
  logic           rsp_dirty;

  logic           take_en;
  logic           sample_en;

  snp_rr_arb #(.N(N)) u_arb (
    .req  (req),
    .last (last_q),
    .any  (arb_any),
    .win  (arb_win)
  );

  snp_resp_sel #(.N(N)) u_rsp (
    .hit       (snp_hit),
    .dirty     (snp_dirty),
    .self_id   (owner_q),
    .any_hit   (rsp_any),
    .sup_id    (rsp_sup),
    .sup_dirty (rsp_dirty)
  );

  assign take_en   = (st_q == ST_IDLE) && arb_any;
  assign sample_en = (st_q == ST_SAMPLE);

  // Next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (arb_any) st_d = ST_ADDR;
      ST_ADDR:    st_d = ST_WAIT;
      ST_WAIT:    st_d = ST_SAMPLE;
      ST_SAMPLE: begin
        if (cmd_q == CMD_INV) st_d = ST_INVDONE;
        else if (rsp_any)     st_d = ST_CACHE;
        else                  st_d = ST_MEM;
      end
      ST_CACHE:   st_d = ST_IDLE;
      ST_INVDONE: st_d = ST_IDLE;
      ST_MEM:     if (mem_rd_valid) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // Transaction capture at grant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      last_q  <= IDW'(N - 1);
      cmd_q   <= CMD_NONE;
      addr_q  <= '0;
    end else if (take_en) begin
      owner_q <= arb_win;
      last_q  <= arb_win;
      cmd_q   <= snp_cmd_e'(req_cmd[2*arb_win +: 2]);
      addr_q  <= req_addr[AW*arb_win +: AW];
    end
  end

  // Snoop reply capture, fixed two cycles after the address phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_q   <= 1'b0;
      sup_q      <= '0;
      supdirty_q <= 1'b0;
    end else if (sample_en) begin
      shared_q   <= rsp_any;
      sup_q      <= rsp_sup;
      supdirty_q <= rsp_dirty;
    end
  end

  // Outputs
  always_comb begin
    gnt            = '0;
    bus_supplier   = '0;
    bus_data       = '0;
    bus_data_valid = 1'b0;
    bus_done       = 1'b0;
    if (st_q != ST_IDLE) gnt[owner_q] = 1'b1;
    unique case (st_q)
      ST_CACHE: begin
        bus_supplier[sup_q] = 1'b1;
        bus_data            = snp_data[DW*sup_q +: DW];
        bus_data_valid      = 1'b1;
        bus_done            = 1'b1;
      end
      ST_INVDONE: bus_done = 1'b1;
      ST_MEM: begin
        bus_data       = mem_rd_data;
        bus_data_valid = mem_rd_valid;
        bus_done       = mem_rd_valid;
      end
      default: ;
    endcase
  end

  assign bus_valid    = (st_q == ST_ADDR);
  assign bus_cmd      = (st_q == ST_IDLE) ? CMD_NONE : cmd_q;
  assign bus_addr     = addr_q;
  assign bus_src      = owner_q;
  assign bus_shared   = shared_q && bus_done;
  assign mem_rd_req   = (st_q == ST_ADDR) && (cmd_q != CMD_INV);
  assign mem_rd_abort = (st_q == ST_CACHE);
  assign mem_wr       = (st_q == ST_CACHE) && supdirty_q;
  assign mem_wr_addr  = addr_q;
  assign mem_wr_data  = bus_data;

endmodule

// File: rtl/snp_bus_ctrl_chk.sv
module snp_bus_ctrl_chk #(
  parameter int N  = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  gnt,
  input logic          bus_valid,
  input logic [1:0]    bus_cmd,
  input logic [N-1:0]  bus_supplier,
  input logic [DW-1:0] bus_data,
  input logic          bus_data_valid,
  input logic          bus_done,
  input logic          mem_rd_req,
  input logic          mem_rd_abort,
  input logic          mem_wr,
  input logic [DW-1:0] mem_wr_data
);

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_gnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !bus_done) |=> (gnt == $past(gnt)));

  assert_gnt_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> (gnt == '0));

  assert_addr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> !bus_valid);

  assert_addr_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $onehot(gnt));

  assert_memreq_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (bus_valid && bus_cmd != 2'b11));

  assert_abort_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_abort |-> (bus_data_valid && bus_done && $onehot(bus_supplier)));

  assert_wb_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_rd_abort && mem_wr_data == bus_data));

  assert_data_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_valid |-> bus_done);

  assert_inv_nodata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && bus_cmd == 2'b11) |-> (!bus_data_valid && !mem_wr));

endmodule

bind snp_bus_ctrl snp_bus_ctrl_chk #(.N(N), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .gnt            (gnt),
  .bus_valid      (bus_valid),
  .bus_cmd        (bus_cmd),
  .bus_supplier   (bus_supplier),
  .bus_data       (bus_data),
  .bus_data_valid (bus_data_valid),
  .bus_done       (bus_done),
  .mem_rd_req     (mem_rd_req),
  .mem_rd_abort   (mem_rd_abort),
  .mem_wr         (mem_wr),
  .mem_wr_data    (mem_wr_data)
);

// File: tb/test_snp_bus_ctrl.sv
`timescale 1ns/100ps
module test_snp_bus_ctrl;

  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IDW = $clog2(N);

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req;
  logic [2*N-1:0]  req_cmd;
  logic [N*AW-1:0] req_addr;
  logic [N-1:0]    gnt;
  logic            bus_valid;
  logic [1:0]      bus_cmd;
  logic [AW-1:0]   bus_addr;
  logic [IDW-1:0]  bus_src;
  logic [N-1:0]    snp_hit, snp_dirty;
  logic [N*DW-1:0] snp_data;
  logic [N-1:0]    bus_supplier;
  logic [DW-1:0]   bus_data;
  logic            bus_data_valid, bus_shared, bus_done;
  logic            mem_rd_req, mem_rd_abort, mem_rd_valid;
  logic [DW-1:0]   mem_rd_data;
  logic            mem_wr;
  logic [AW-1:0]   mem_wr_addr;
  logic [DW-1:0]   mem_wr_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_w = N - 1;
  int mcnt = 0;
  bit stale = 0;

  snp_bus_ctrl #(.N(N), .AW(AW), .DW(DW)) i_snp_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_cmd(req_cmd), .req_addr(req_addr),
    .gnt(gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_src(bus_src), .snp_hit(snp_hit), .snp_dirty(snp_dirty), .snp_data(snp_data),
    .bus_supplier(bus_supplier), .bus_data(bus_data), .bus_data_valid(bus_data_valid),
    .bus_shared(bus_shared), .bus_done(bus_done), .mem_rd_req(mem_rd_req),
    .mem_rd_abort(mem_rd_abort), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] lane(input int c);
    return 32'hC0DE_0000 + DW'(c) * 32'h111;
  endfunction

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return 32'h5EED_0000 ^ {16'h0, a};
  endfunction

  function automatic int rr_pick(input logic [N-1:0] m, input int last);
    for (int k = 1; k <= N; k++) if (m[(last + k) % N]) return (last + k) % N;
    return -1;
  endfunction

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  // Memory: answers four cycles after the request unless cancelled
  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= 0;
      mem_rd_valid <= 1'b0;
    end else begin
      mem_rd_valid <= 1'b0;
      if (mem_rd_req) begin
        mcnt <= 1;
        mem_rd_data <= memval(bus_addr);
      end else if (mem_rd_abort && !stale) mcnt <= 0;
      else if (mcnt == 3) begin
        mem_rd_valid <= 1'b1;
        mcnt <= 0;
      end else if (mcnt != 0) mcnt <= mcnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setreq(input int c, input logic [1:0] cmd, input logic [AW-1:0] a);
    req[c] = 1'b1;
    req_cmd[2*c +: 2] = cmd;
    req_addr[AW*c +: AW] = a;
  endtask

  // One transaction, entered at a negedge of an idle cycle with requests set.
  task automatic txn(input logic [N-1:0] hitv, input logic [N-1:0] dirtyv);
    int w, sup;
    logic [1:0] c;
    logic [AW-1:0] a;
    logic [N-1:0] oth;
    w = rr_pick(req, last_w);
    c = req_cmd[2*w +: 2];
    a = req_addr[AW*w +: AW];
    oth = hitv & ~(N'(1) << w);
    sup = lowest(oth);
    snp_hit = '1; snp_dirty = '1;
    step(); // address phase
    chk("R2 gnt winner", gnt, N'(1) << w);
    chk("R3 bus_valid", bus_valid, 1);
    chk("R3 bus_cmd", bus_cmd, c);
    chk("R3 bus_addr", bus_addr, a);
    chk("R3 bus_src", bus_src, w);
    chk("R3 mem_rd_req", mem_rd_req, c != 2'b11);
    step();
    chk("R3 bus_valid single", bus_valid, 0);
    chk("R2 gnt held", gnt, N'(1) << w);
    step(); // sample cycle
    snp_hit = hitv; snp_dirty = dirtyv;
    chk("R4 no early done", bus_done, 0);
    step();
    snp_hit = '1; snp_dirty = '1;
    if (c == 2'b11) begin
      chk("R10 inv done", bus_done, 1);
      chk("R10 inv no data", bus_data_valid, 0);
      chk("R10 inv no mem_wr", mem_wr, 0);
      chk("R5 shared inv", bus_shared, oth != 0);
    end else if (sup >= 0) begin
      chk("R6 data_valid", bus_data_valid, 1);
      chk("R6 done", bus_done, 1);
      chk("R6 abort", mem_rd_abort, 1);
      chk("R6 data lane", bus_data, lane(sup));
      chk("R6 supplier", bus_supplier, N'(1) << sup);
      chk("R5 shared", bus_shared, 1);
      chk("R7 mem_wr", mem_wr, dirtyv[sup]);
      if (dirtyv[sup]) begin
        chk("R7 wr addr", mem_wr_addr, a);
        chk("R7 wr data", mem_wr_data, lane(sup));
      end
    end else begin
      chk("R8 waits for memory", bus_done, 0);
      step();
      chk("R8 mem done", bus_done, 1);
      chk("R8 mem data_valid", bus_data_valid, 1);
      chk("R8 mem data", bus_data, memval(a));
      chk("R5 not shared", bus_shared, 0);
    end
    req[w] = 1'b0;
    last_w = w;
    step(); // idle cycle
    chk("R2 gnt released", gnt, 0);
    chk("R9 no late done", bus_done, 0);
    chk("R9 no late data", bus_data_valid, 0);
    snp_hit = '0; snp_dirty = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    req = '0; req_cmd = '0; req_addr = '0;
    snp_hit = '0; snp_dirty = '0;
    for (int i = 0; i < N; i++) snp_data[DW*i +: DW] = lane(i);
    repeat (3) @(negedge clk);
    chk("R1 reset gnt", gnt, 0);
    chk("R1 reset strobes", {bus_valid, bus_done, bus_data_valid, mem_rd_req, mem_rd_abort, mem_wr}, 0);
    rst_n = 1'b1;
    step();
    chk("R1 idle gnt", gnt, 0);
    chk("R1 idle strobes", {bus_valid, bus_done, bus_data_valid, mem_rd_req, mem_rd_abort, mem_wr}, 0);

    // R8: read miss served by memory
    setreq(1, 2'b01, 16'h0100);
    txn(4'b0000, 4'b0000);
    // R6: several sharers, lowest other wins
    setreq(0, 2'b01, 16'h0240);
    txn(4'b1100, 4'b0000);
    // R4/R7: own hit ignored, dirty supplier written back
    setreq(1, 2'b01, 16'h0380);
    txn(4'b0011, 4'b0001);
    // R6/R7: read-for-ownership from a Modified holder
    setreq(3, 2'b10, 16'h04C0);
    txn(4'b0100, 4'b0100);
    // R10: invalidate with sharers
    setreq(2, 2'b11, 16'h0500);
    txn(4'b1011, 4'b0000);
    // R4/R5: invalidate where only the requester hits
    setreq(3, 2'b11, 16'h0600);
    txn(4'b1000, 4'b0000);
    // R9: memory answers anyway after an intervention
    stale = 1;
    setreq(0, 2'b01, 16'h0700);
    txn(4'b0010, 4'b0000);
    stale = 0;
    step();
    // R2: round-robin order with several requesters
    setreq(0, 2'b11, 16'h0800);
    setreq(1, 2'b11, 16'h0810);
    setreq(3, 2'b11, 16'h0830);
    while (req != '0) txn(4'b0000, 4'b0000);
    setreq(0, 2'b11, 16'h0900);
    setreq(1, 2'b01, 16'h0910);
    setreq(2, 2'b11, 16'h0920);
    setreq(3, 2'b11, 16'h0930);
    while (req != '0) txn(4'b0001, 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule